// File: doc/BRIEF.md
# Four-Station Track Segment Cleaner

This block receives the azimuth positions of one candidate track's segments in four detector stations, one track per clock. It checks whether the station-3 segment fits a straight path through the other three. If it does not, the block removes that segment from the momentum estimate. It forms the signed pairwise azimuth differences between stations and compares their magnitudes. It then passes two differences on to a later momentum lookup: the 1-2 and 2-3 pair for a normal track, or the 1-2 and 2-4 pair when station 3 is discarded.

A segment that is not collinear makes a long jump from station 1 to station 3, and that jump is larger than the short 1-2 step. The same segment makes a 2-3 step longer than the 2-4 span. The rule also needs the 1-3 jump to exceed a programmable threshold, so that small scatter on a genuine track never triggers a drop. Azimuths are unsigned numbers in half-strip units, and the threshold uses the same units. A four-bit mask marks which stations actually carry a segment. The rule applies only to fully populated tracks. The design has two register stages: differences first, then comparison and selection.

Top module: `seg_cleaner`

## Requirements
- R1: While reset is asserted and on the first cycles after it, `out_valid`, `st3_drop`, `dphi_a` and `dphi_b` are all zero.
- R2: A track presented with `in_valid` high at a rising edge appears with `out_valid` high exactly two rising edges later. A new track may be presented on every cycle.
- R3: `dphi_a` is always the station 1-to-2 difference phi2 − phi1. It is signed and one bit wider than an azimuth, so the full range from −4095 to +4095 is exact.
- R4: `st3_drop` is 1 exactly when all three conditions hold: |phi3−phi1| > |phi2−phi1|, |phi3−phi2| > |phi4−phi2|, and |phi3−phi1| > `thresh`.
- R5: All three comparisons are strict: a tie in any one of them leaves `st3_drop` at 0.
- R6: When `st3_drop` is 1, `dphi_b` carries the station 2-to-4 difference phi4 − phi2.
- R7: When `st3_drop` is 0, `dphi_b` carries the station 2-to-3 difference phi3 − phi2.
- R8: If any bit of `st_valid` is 0 (bit i−1 marks station i), `st3_drop` is 0 and the normal pair of R3 and R7 is output.
- R9: `thresh` is sampled in the same cycle as the track it applies to. A later change of `thresh` does not alter a track already accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Track present on the inputs this cycle |
| st_valid | input | 4 | Per-station segment present, bit 0 = station 1 |
| phi1 | input | PHI_W | Station 1 azimuth, half strips |
| phi2 | input | PHI_W | Station 2 azimuth, half strips |
| phi3 | input | PHI_W | Station 3 azimuth, half strips |
| phi4 | input | PHI_W | Station 4 azimuth, half strips |
| thresh | input | PHI_W | Drop threshold on the 1-3 magnitude, half strips |
| out_valid | output | 1 | Result present |
| st3_drop | output | 1 | Station 3 segment discarded |
| dphi_a | output | PHI_W+1 | First difference for momentum lookup (signed) |
| dphi_b | output | PHI_W+1 | Second difference for momentum lookup (signed) |

## Verification
Uniformly random azimuths almost never produce the cases that matter: a drop decision that hangs on one exact tie, or a 1-3 magnitude that sits exactly on the threshold. The stimulus therefore builds most tracks as a random base with small half-strip offsets, so the differences fall in the same few-strip range as the threshold. Directed tracks then place each comparison exactly at equality and one step past it, and a full-scale track checks the signed range. A further directed pair changes the threshold in the cycle after a track is accepted, which checks that the threshold is captured with that track.

// File: rtl/seg_cleaner.sv
module seg_cleaner #(
  parameter int PHI_W = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [3:0]         st_valid,
  input  logic [PHI_W-1:0]   phi1,
  input  logic [PHI_W-1:0]   phi2,
  input  logic [PHI_W-1:0]   phi3,
  input  logic [PHI_W-1:0]   phi4,
  input  logic [PHI_W-1:0]   thresh,
  output logic               out_valid,
  output logic               st3_drop,
  output logic signed [PHI_W:0] dphi_a,
  output logic signed [PHI_W:0] dphi_b
);
  localparam int DW = PHI_W + 1;

  function automatic logic signed [DW-1:0] diff(input logic [PHI_W-1:0] from, input logic [PHI_W-1:0] to);
    return $signed({1'b0, to}) - $signed({1'b0, from});
  endfunction

  function automatic logic [PHI_W-1:0] mag(input logic signed [DW-1:0] v);
    logic signed [DW-1:0] n;
    n = v[DW-1] ? -v : v;
    return n[PHI_W-1:0];
  endfunction

  logic                 s1_v, s1_full;
  logic signed [DW-1:0] s1_d12, s1_d13, s1_d23, s1_d24;
  logic [PHI_W-1:0]     s1_thr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_v    <= 1'b0;
      s1_full <= 1'b0;
      s1_d12  <= '0;
      s1_d13  <= '0;
      s1_d23  <= '0;
      s1_d24  <= '0;
      s1_thr  <= '0;
    end else begin
      s1_v <= in_valid;
      if (in_valid) begin
        s1_full <= &st_valid;
        s1_d12  <= diff(phi1, phi2);
        s1_d13  <= diff(phi1, phi3);
        s1_d23  <= diff(phi2, phi3);
        s1_d24  <= diff(phi2, phi4);
        s1_thr  <= thresh;
      end
    end
  end

  logic [PHI_W-1:0] m12, m13, m23, m24;
  logic             drop_c;

  assign m12 = mag(s1_d12);
  assign m13 = mag(s1_d13);
  assign m23 = mag(s1_d23);
  assign m24 = mag(s1_d24);
  assign drop_c = s1_full && (m13 > m12) && (m23 > m24) && (m13 > s1_thr);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      st3_drop  <= 1'b0;
      dphi_a    <= '0;
      dphi_b    <= '0;
    end else begin
      out_valid <= s1_v;
      st3_drop  <= s1_v && drop_c;
      if (s1_v) begin
        dphi_a <= s1_d12;
        dphi_b <= drop_c ? s1_d24 : s1_d23;
      end
    end
  end
endmodule

// File: rtl/seg_cleaner_chk.sv
module seg_cleaner_chk #(
  parameter int PHI_W = 12
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic [3:0]         st_valid,
  input logic [PHI_W-1:0]   phi1,
  input logic [PHI_W-1:0]   phi2,
  input logic [PHI_W-1:0]   phi3,
  input logic [PHI_W-1:0]   phi4,
  input logic               out_valid,
  input logic               st3_drop,
  input logic signed [PHI_W:0] dphi_a,
  input logic signed [PHI_W:0] dphi_b
);
  logic [1:0] age;
  always_ff @(posedge clk) begin
    if (!rst_n) age <= '0;
    else if (age != 2'd2) age <= age + 2'd1;
  end

  logic signed [PHI_W:0] w21, w32, w42;
  assign w21 = $signed({1'b0, phi2}) - $signed({1'b0, phi1});
  assign w32 = $signed({1'b0, phi3}) - $signed({1'b0, phi2});
  assign w42 = $signed({1'b0, phi4}) - $signed({1'b0, phi2});

  AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |=> !out_valid && !st3_drop); // R1
  AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n) (age == 2'd2) |-> out_valid == $past(in_valid, 2)); // R2
  AST_FIRST_DIFF: assert property (@(posedge clk) disable iff (!rst_n) (age == 2'd2 && out_valid) |-> dphi_a == $past(w21, 2)); // R3
  AST_DROP_PAIR: assert property (@(posedge clk) disable iff (!rst_n) (age == 2'd2 && st3_drop) |-> dphi_b == $past(w42, 2)); // R6
  AST_KEEP_PAIR: assert property (@(posedge clk) disable iff (!rst_n) (age == 2'd2 && out_valid && !st3_drop) |-> dphi_b == $past(w32, 2)); // R7
  AST_DROP_NEEDS_ALL: assert property (@(posedge clk) disable iff (!rst_n) (age == 2'd2 && st3_drop) |-> $past(&st_valid, 2)); // R8
  AST_DROP_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n) st3_drop |-> out_valid); // R4
endmodule

bind seg_cleaner seg_cleaner_chk #(.PHI_W(PHI_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .st_valid(st_valid),
  .phi1(phi1), .phi2(phi2), .phi3(phi3), .phi4(phi4),
  .out_valid(out_valid), .st3_drop(st3_drop), .dphi_a(dphi_a), .dphi_b(dphi_b)
);

// File: tb/tb_seg_cleaner.sv
`timescale 1ns/1ps
module tb_seg_cleaner;
  localparam int W = 12;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, in_valid;
  logic [3:0] st_valid;
  logic [W-1:0] phi1, phi2, phi3, phi4, thresh;
  logic out_valid, st3_drop;
  logic signed [W:0] dphi_a, dphi_b;

  seg_cleaner #(.PHI_W(W)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .st_valid(st_valid),
    .phi1(phi1), .phi2(phi2), .phi3(phi3), .phi4(phi4), .thresh(thresh),
    .out_valid(out_valid), .st3_drop(st3_drop), .dphi_a(dphi_a), .dphi_b(dphi_b)
  );

  int checks = 0, errors = 0;
  bit done = 0;

  logic ev[2], ed[2];
  int   ea[2], eb[2];

  function automatic int iabs(int v);
    return v < 0 ? -v : v;
  endfunction

  task automatic check_out();
    checks++;
    if (out_valid !== ev[1]) begin
      errors++; $display("FAIL R2 out_valid got %0b exp %0b", out_valid, ev[1]);
    end else if (st3_drop !== ed[1]) begin
      errors++; $display("FAIL R4/R5/R8 st3_drop got %0b exp %0b", st3_drop, ed[1]);
    end else if (ev[1] && int'(dphi_a) != ea[1]) begin
      errors++; $display("FAIL R3 dphi_a got %0d exp %0d", dphi_a, ea[1]);
    end else if (ev[1] && int'(dphi_b) != eb[1]) begin
      errors++; $display("FAIL %s dphi_b got %0d exp %0d", ed[1] ? "R6" : "R7", dphi_b, eb[1]);
    end
  endtask

  task automatic apply(input logic v, input logic [3:0] sv, input int p1, input int p2,
                       input int p3, input int p4, input int th);
    int d12, d13, d23, d24;
    logic dr;
    @(negedge clk);
    check_out();
    ev[1] = ev[0]; ed[1] = ed[0]; ea[1] = ea[0]; eb[1] = eb[0];
    in_valid = v; st_valid = sv;
    phi1 = p1[W-1:0]; phi2 = p2[W-1:0]; phi3 = p3[W-1:0]; phi4 = p4[W-1:0]; thresh = th[W-1:0];
    d12 = int'(phi2) - int'(phi1); d13 = int'(phi3) - int'(phi1);
    d23 = int'(phi3) - int'(phi2); d24 = int'(phi4) - int'(phi2);
    dr = v && (sv == 4'hF) && iabs(d13) > iabs(d12) && iabs(d23) > iabs(d24) && iabs(d13) > int'(thresh);
    ev[0] = v; ed[0] = dr;
    if (v) begin ea[0] = d12; eb[0] = dr ? d24 : d23; end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int base, th;
    logic [3:0] sv;
    void'($urandom(32'd7741));
    rst_n = 0; in_valid = 0; st_valid = 0;
    phi1 = 0; phi2 = 0; phi3 = 0; phi4 = 0; thresh = 0;
    ev = '{0, 0}; ed = '{0, 0}; ea = '{0, 0}; eb = '{0, 0};
    repeat (4) begin
      @(negedge clk);
      checks++;
      if (out_valid !== 0 || st3_drop !== 0 || dphi_a !== 0 || dphi_b !== 0) begin
        errors++; $display("FAIL R1 reset outputs got %0b %0b %0d %0d exp 0 0 0 0", out_valid, st3_drop, dphi_a, dphi_b);
      end
    end
    rst_n = 1;
    // R5: ties in each comparison
    apply(1, 4'hF, 100, 102, 104, 104, 1);   // 13=4>12=2, 23=2 vs 24=2 tie -> keep
    apply(1, 4'hF, 100, 102, 102, 103, 1);   // 13=2 == 12=2 tie -> keep
    apply(1, 4'hF, 100, 102, 106, 103, 6);   // 13=6 == thresh tie -> keep
    apply(1, 4'hF, 100, 102, 106, 103, 5);   // R4 drop
    apply(1, 4'hF, 200, 199, 190, 198, 2);   // R4/R6 negative-direction drop
    // R8: one station missing blocks a drop
    apply(1, 4'h7, 100, 102, 106, 103, 5);
    apply(1, 4'hE, 100, 102, 106, 103, 5);
    // R3: full-scale signed range
    apply(1, 4'hF, 0, 4095, 0, 4095, 0);
    apply(1, 4'hF, 4095, 0, 4095, 0, 0);
    // R9: threshold change right after a track
    apply(1, 4'hF, 100, 102, 110, 103, 20);  // keep at 20
    apply(0, 4'hF, 100, 102, 110, 103, 1);   // bubble with low thresh
    apply(1, 4'hF, 100, 102, 110, 103, 1);   // drop at 1
    // R2: gaps and back-to-back
    apply(0, 4'h0, 0, 0, 0, 0, 0);
    apply(1, 4'hF, 10, 11, 12, 13, 0);
    apply(1, 4'hF, 10, 11, 30, 12, 0);
    for (int i = 0; i < 4000; i++) begin
      base = $urandom_range(0, 4095);
      sv = ($urandom_range(0, 3) != 0) ? 4'hF : 4'($urandom_range(0, 15));
      th = $urandom_range(0, 24);
      if ($urandom_range(0, 3) != 0)
        apply($urandom_range(0, 4) != 0, sv, base, base + $urandom_range(0, 8) - 4,
              base + $urandom_range(0, 24) - 12, base + $urandom_range(0, 8) - 4, th);
      else
        apply($urandom_range(0, 4) != 0, sv, base, $urandom_range(0, 4095),
              $urandom_range(0, 4095), $urandom_range(0, 4095), $urandom_range(0, 4095));
    end
    apply(0, 4'h0, 0, 0, 0, 0, 0);
    apply(0, 4'h0, 0, 0, 0, 0, 0);
    apply(0, 4'h0, 0, 0, 0, 0, 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule